// File: doc/BRIEF.md
# TLB Protection-Violation Exception Entry Sequencer

This block handles the processor-side entry into an exception when the address translation unit refuses an access. The TLB lookup finds a valid entry that matches the virtual address, but the entry's access rights do not allow the requested load or store. The lookup then raises a single-cycle violation pulse. With that pulse it supplies the faulting virtual address, the access direction, the way that matched, the current PC, a delay-slot flag with the address of the related branch, the live status register and the vector base register.

On an accepted pulse, the sequencer builds register images in one step: the page-table-entry-high image, the fault address, the exception event code, the saved PC, the saved status, the new status and the replacement way for the MMU control register. The owning register file writes all of them together in the cycle marked by `commit_o`. In the cycle after that, the fetch unit receives a redirect to the handler at the vector base plus 0x100.

If a violation arrives while exceptions are already masked, or while an entry is still in progress, the sequencer does not start a new entry. It raises a separate nested-fault pulse, which the reset logic handles.

Top module: `tlb_prot_entry`

## Requirements
- R1: After synchronous reset, `commit_o`, `redir_valid_o` and `nested_fault_o` are 0, and every register image output is 0.
- R2: A violation is accepted when `viol_i` is 1, `sr_i[28]` (the block bit) is 0 and no entry is in progress. `commit_o` is then 1 for exactly the one cycle after the pulse. Without `viol_i`, no output changes.
- R3: On commit, `pteh_o` holds `vaddr_i[31:10]` in the same bit positions with bits 9:0 cleared, and `fault_va_o` holds all 32 bits of `vaddr_i`.
- R4: On commit, `event_o` is 12'h0A0 when `is_store_i` was 0 (load) and 12'h0C0 when it was 1 (store).
- R5: On commit, `saved_pc_o` holds `pc_i`, or `branch_pc_i` when `in_dslot_i` was 1.
- R6: On commit, `saved_sr_o` holds `sr_i` unchanged as it was at the pulse. `sr_new_o` holds that same value with bit 30 (privileged mode), bit 29 (register bank) and bit 28 (block) set to 1.
- R7: On commit, `repl_way_o` holds the 2-bit `way_i` of the faulting way.
- R8: `redir_valid_o` is 1 for exactly the one cycle after `commit_o`. In that cycle `redir_pc_o` equals `vbr_i` plus 32'h100, modulo 2^32, with `vbr_i` taken at the pulse.
- R9: A pulse that arrives while `sr_i[28]` is 1 produces no commit and no redirect, and leaves every image unchanged. Instead `nested_fault_o` is 1 for the one cycle after the pulse.
- R10: A pulse that arrives during the commit cycle or the redirect cycle of an earlier entry raises `nested_fault_o` in the following cycle. The earlier entry's images and redirect carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| viol_i | input | 1 | Protection-violation pulse from the TLB lookup |
| vaddr_i | input | 32 | Faulting virtual address |
| is_store_i | input | 1 | Access direction, 1 for store, 0 for load |
| way_i | input | 2 | Way number of the matching entry |
| pc_i | input | 32 | Address of the faulting instruction |
| in_dslot_i | input | 1 | Faulting instruction sits in a delay slot |
| branch_pc_i | input | 32 | Address of the delayed branch owning the slot |
| sr_i | input | 32 | Live status register |
| vbr_i | input | 32 | Vector base register |
| commit_o | output | 1 | All register images are to be written this cycle |
| pteh_o | output | 32 | Page-table-entry-high image (page number only) |
| fault_va_o | output | 32 | Fault-address image |
| event_o | output | 12 | Exception event code image |
| saved_pc_o | output | 32 | Saved-PC image |
| saved_sr_o | output | 32 | Saved-status image |
| sr_new_o | output | 32 | New status register image |
| repl_way_o | output | 2 | Replacement-way field for the MMU control register |
| redir_valid_o | output | 1 | Fetch redirect request |
| redir_pc_o | output | 32 | Handler address for the redirect |
| nested_fault_o | output | 1 | Violation while masked or busy, reset-class error |

## Verification
The case that needs most care is a second violation pulse landing in the commit cycle of a first entry. In that cycle, the images of the first fault must appear on the outputs while the nesting check judges the new pulse. The bench holds `viol_i` high across two cycles with a different address and access direction in the second. In the following cycle it requires `redir_valid_o` and `nested_fault_o` to be high together, with the redirect target and fault address still those of the first fault. A separate directed case raises the block bit at the pulse, confirming that masking alone, with the sequencer idle, also diverts the pulse to the nested-fault output.

// File: rtl/pve_pkg.sv
package pve_pkg;

    localparam int XLEN = 32;
    localparam int EVT_W = 12;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [EVT_W-1:0] evt_t;

    localparam evt_t EVT_LOAD_DENIED  = 12'h0A0;
    localparam evt_t EVT_STORE_DENIED = 12'h0C0;

    typedef enum logic [1:0] {
        PVE_IDLE   = 2'd0,
        PVE_COMMIT = 2'd1,
        PVE_REDIR  = 2'd2
    } pve_state_e;

    typedef struct packed {
        word_t pteh;
        word_t fault_va;
        evt_t  evt;
        word_t spc;
        word_t ssr;
        word_t sr;
    } entry_img_t;

    function automatic evt_t evt_for(input logic store);
        return store ? EVT_STORE_DENIED : EVT_LOAD_DENIED;
    endfunction

    function automatic word_t page_image(input word_t va, input int lsb);
        word_t keep;
        keep = '1;
        keep = keep << lsb;
        return va & keep;
    endfunction

endpackage

// File: rtl/pve_ctrl.sv
module pve_ctrl
    import pve_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic viol_i,
    input  logic blocked_i,
    output logic cap_en_o,
    output logic commit_o,
    output logic redir_valid_o,
    output logic nested_o
);

    pve_state_e state_q, state_d;
    logic       nested_q;
    logic       idle;

    assign idle     = (state_q == PVE_IDLE);
    assign cap_en_o = viol_i && idle && !blocked_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PVE_IDLE:   if (cap_en_o) state_d = PVE_COMMIT;
            PVE_COMMIT: state_d = PVE_REDIR;
            PVE_REDIR:  state_d = PVE_IDLE;
            default:    state_d = PVE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PVE_IDLE;
            nested_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            nested_q <= viol_i && !cap_en_o;
        end
    end

    assign commit_o      = (state_q == PVE_COMMIT);
    assign redir_valid_o = (state_q == PVE_REDIR);
    assign nested_o      = nested_q;

    a_r2_commit_after_accept: assert property (@(posedge clk) disable iff (rst)
        cap_en_o |=> commit_o);

    a_r2_commit_single: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !commit_o);

    a_r8_redir_after_commit: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> (redir_valid_o && !commit_o));

    a_r9_masked_nested: assert property (@(posedge clk) disable iff (rst)
        (viol_i && blocked_i) |=> (nested_o && !commit_o));

    a_r10_busy_nested: assert property (@(posedge clk) disable iff (rst)
        (viol_i && (commit_o || redir_valid_o)) |=> nested_o);

endmodule

// File: rtl/pve_capture.sv
module pve_capture
    import pve_pkg::*;
#(
    parameter int WAYS    = 4,
    parameter int VPN_LSB = 10,
    parameter int MD_BIT  = 30,
    parameter int RB_BIT  = 29,
    parameter int BL_BIT  = 28,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en_i,
    input  logic             commit_i,
    input  word_t            vaddr_i,
    input  logic             is_store_i,
    input  logic [WAY_W-1:0] way_i,
    input  word_t            pc_i,
    input  logic             in_dslot_i,
    input  word_t            branch_pc_i,
    input  word_t            sr_i,
    output entry_img_t       img_o,
    output logic [WAY_W-1:0] way_o
);

    localparam word_t ENTRY_SET = (word_t'(1) << MD_BIT)
                                | (word_t'(1) << RB_BIT)
                                | (word_t'(1) << BL_BIT);

    entry_img_t       img_q, img_d;
    logic [WAY_W-1:0] way_q;

    always_comb begin
        img_d.pteh     = page_image(vaddr_i, VPN_LSB);
        img_d.fault_va = vaddr_i;
        img_d.evt      = evt_for(is_store_i);
        img_d.spc      = in_dslot_i ? branch_pc_i : pc_i;
        img_d.ssr      = sr_i;
        img_d.sr       = sr_i | ENTRY_SET;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            img_q <= '0;
            way_q <= '0;
        end else if (cap_en_i) begin
            img_q <= img_d;
            way_q <= way_i;
        end
    end

    assign img_o = img_q;
    assign way_o = way_q;

    a_r3_page_low_clear: assert property (@(posedge clk) disable iff (rst)
        commit_i |-> (img_o.pteh[VPN_LSB-1:0] == '0));

    a_r4_event_legal: assert property (@(posedge clk) disable iff (rst)
        commit_i |-> (img_o.evt == EVT_LOAD_DENIED || img_o.evt == EVT_STORE_DENIED));

    a_r6_saved_sr_pre: assert property (@(posedge clk) disable iff (rst)
        cap_en_i |=> (img_o.ssr == $past(sr_i)));

    a_r6_new_sr_bits: assert property (@(posedge clk) disable iff (rst)
        commit_i |-> (img_o.sr[MD_BIT] && img_o.sr[RB_BIT] && img_o.sr[BL_BIT]));

    a_r7_way_kept: assert property (@(posedge clk) disable iff (rst)
        cap_en_i |=> (way_o == $past(way_i)));

    a_r9_hold_without_capture: assert property (@(posedge clk) disable iff (rst)
        !cap_en_i |=> $stable(img_o));

endmodule

// File: rtl/pve_vector.sv
module pve_vector
    import pve_pkg::*;
#(
    parameter word_t VEC_OFS = 32'h0000_0100
)(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_en_i,
    input  word_t vbr_i,
    output word_t target_o
);

    word_t target_q;

    always_ff @(posedge clk) begin
        if (rst)           target_q <= '0;
        else if (cap_en_i) target_q <= vbr_i + VEC_OFS;
    end

    assign target_o = target_q;

    a_r8_target_from_base: assert property (@(posedge clk) disable iff (rst)
        cap_en_i |=> (target_o - $past(vbr_i) == VEC_OFS));

endmodule

// File: rtl/tlb_prot_entry.sv
module tlb_prot_entry
    import pve_pkg::*;
#(
    parameter int    WAYS    = 4,
    parameter int    VPN_LSB = 10,
    parameter int    MD_BIT  = 30,
    parameter int    RB_BIT  = 29,
    parameter int    BL_BIT  = 28,
    parameter word_t VEC_OFS = 32'h0000_0100,
    localparam int   WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             viol_i,
    input  logic [31:0]      vaddr_i,
    input  logic             is_store_i,
    input  logic [WAY_W-1:0] way_i,
    input  logic [31:0]      pc_i,
    input  logic             in_dslot_i,
    input  logic [31:0]      branch_pc_i,
    input  logic [31:0]      sr_i,
    input  logic [31:0]      vbr_i,
    output logic             commit_o,
    output logic [31:0]      pteh_o,
    output logic [31:0]      fault_va_o,
    output logic [11:0]      event_o,
    output logic [31:0]      saved_pc_o,
    output logic [31:0]      saved_sr_o,
    output logic [31:0]      sr_new_o,
    output logic [WAY_W-1:0] repl_way_o,
    output logic             redir_valid_o,
    output logic [31:0]      redir_pc_o,
    output logic             nested_fault_o
);

    logic       cap_en;
    entry_img_t img;

    pve_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .viol_i        (viol_i),
        .blocked_i     (sr_i[BL_BIT]),
        .cap_en_o      (cap_en),
        .commit_o      (commit_o),
        .redir_valid_o (redir_valid_o),
        .nested_o      (nested_fault_o)
    );

    pve_capture #(
        .WAYS    (WAYS),
        .VPN_LSB (VPN_LSB),
        .MD_BIT  (MD_BIT),
        .RB_BIT  (RB_BIT),
        .BL_BIT  (BL_BIT)
    ) u_capture (
        .clk         (clk),
        .rst         (rst),
        .cap_en_i    (cap_en),
        .commit_i    (commit_o),
        .vaddr_i     (vaddr_i),
        .is_store_i  (is_store_i),
        .way_i       (way_i),
        .pc_i        (pc_i),
        .in_dslot_i  (in_dslot_i),
        .branch_pc_i (branch_pc_i),
        .sr_i        (sr_i),
        .img_o       (img),
        .way_o       (repl_way_o)
    );

    pve_vector #(
        .VEC_OFS (VEC_OFS)
    ) u_vector (
        .clk      (clk),
        .rst      (rst),
        .cap_en_i (cap_en),
        .vbr_i    (vbr_i),
        .target_o (redir_pc_o)
    );

    assign pteh_o     = img.pteh;
    assign fault_va_o = img.fault_va;
    assign event_o    = img.evt;
    assign saved_pc_o = img.spc;
    assign saved_sr_o = img.ssr;
    assign sr_new_o   = img.sr;

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!commit_o && !redir_valid_o && !nested_fault_o));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(commit_o && redir_valid_o));

endmodule

// File: tb/sim_tlb_prot_entry.sv
module sim_tlb_prot_entry;

    logic        clk = 1'b0;
    logic        rst;
    logic        viol_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic        is_store_i = 1'b0;
    logic [1:0]  way_i = '0;
    logic [31:0] pc_i = '0;
    logic        in_dslot_i = 1'b0;
    logic [31:0] branch_pc_i = '0;
    logic [31:0] sr_i = '0;
    logic [31:0] vbr_i = '0;
    logic        commit_o;
    logic [31:0] pteh_o, fault_va_o, saved_pc_o, saved_sr_o, sr_new_o, redir_pc_o;
    logic [11:0] event_o;
    logic [1:0]  repl_way_o;
    logic        redir_valid_o, nested_fault_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    tlb_prot_entry u0 (
        .clk(clk), .rst(rst), .viol_i(viol_i), .vaddr_i(vaddr_i),
        .is_store_i(is_store_i), .way_i(way_i), .pc_i(pc_i),
        .in_dslot_i(in_dslot_i), .branch_pc_i(branch_pc_i), .sr_i(sr_i),
        .vbr_i(vbr_i), .commit_o(commit_o), .pteh_o(pteh_o),
        .fault_va_o(fault_va_o), .event_o(event_o), .saved_pc_o(saved_pc_o),
        .saved_sr_o(saved_sr_o), .sr_new_o(sr_new_o), .repl_way_o(repl_way_o),
        .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o),
        .nested_fault_o(nested_fault_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] va, input logic st, input logic [1:0] w,
                         input logic [31:0] pc, input logic ds, input logic [31:0] bpc,
                         input logic [31:0] sr, input logic [31:0] vbr);
        vaddr_i = va; is_store_i = st; way_i = w; pc_i = pc;
        in_dslot_i = ds; branch_pc_i = bpc; sr_i = sr; vbr_i = vbr;
    endtask

    task automatic t_reset();
        chk("R1 commit", {31'd0, commit_o}, 0);
        chk("R1 redir", {31'd0, redir_valid_o}, 0);
        chk("R1 nested", {31'd0, nested_fault_o}, 0);
        chk("R1 pteh", pteh_o, 0);
        chk("R1 fault_va", fault_va_o, 0);
        chk("R1 saved_sr", saved_sr_o, 0);
        chk("R1 redir_pc", redir_pc_o, 0);
    endtask

    task automatic t_load_plain();
        @(negedge clk);
        drive(32'h1234_5678, 1'b0, 2'd2, 32'h0C00_1000, 1'b0, 32'h0C00_0FFC,
              32'h0000_00F0, 32'h8000_0000);
        viol_i = 1'b1;
        @(negedge clk);
        viol_i = 1'b0;
        drive('0, 1'b1, 2'd0, '0, 1'b1, '0, '0, '0);
        chk("R2 commit", {31'd0, commit_o}, 1);
        chk("R8 redir not yet", {31'd0, redir_valid_o}, 0);
        chk("R3 pteh", pteh_o, 32'h1234_5400);
        chk("R3 fault_va", fault_va_o, 32'h1234_5678);
        chk("R4 load event", {20'd0, event_o}, 32'h0A0);
        chk("R5 pc", saved_pc_o, 32'h0C00_1000);
        chk("R6 saved_sr", saved_sr_o, 32'h0000_00F0);
        chk("R6 new sr", sr_new_o, 32'h7000_00F0);
        chk("R7 way", {30'd0, repl_way_o}, 2);
        @(negedge clk);
        chk("R2 commit single", {31'd0, commit_o}, 0);
        chk("R8 redir", {31'd0, redir_valid_o}, 1);
        chk("R8 target", redir_pc_o, 32'h8000_0100);
        @(negedge clk);
        chk("R8 redir single", {31'd0, redir_valid_o}, 0);
    endtask

    task automatic t_store_dslot();
        @(negedge clk);
        drive(32'hFFFF_FFFF, 1'b1, 2'd3, 32'h0000_2002, 1'b1, 32'h0000_2000,
              32'h4000_0003, 32'hFFFF_FF80);
        viol_i = 1'b1;
        @(negedge clk);
        viol_i = 1'b0;
        chk("R2 commit store", {31'd0, commit_o}, 1);
        chk("R3 pteh all ones", pteh_o, 32'hFFFF_FC00);
        chk("R4 store event", {20'd0, event_o}, 32'h0C0);
        chk("R5 dslot branch", saved_pc_o, 32'h0000_2000);
        chk("R6 saved_sr", saved_sr_o, 32'h4000_0003);
        chk("R6 new sr", sr_new_o, 32'h7000_0003);
        chk("R7 way 3", {30'd0, repl_way_o}, 3);
        @(negedge clk);
        chk("R8 wrap target", redir_pc_o, 32'h0000_0080);
        chk("R8 redir", {31'd0, redir_valid_o}, 1);
    endtask

    task automatic t_idle_hold();
        @(negedge clk);
        drive(32'hDEAD_BEEF, 1'b0, 2'd1, 32'h1111_1111, 1'b0, '0, '0, 32'h1000_0000);
        repeat (4) @(negedge clk);
        chk("R2 no commit", {31'd0, commit_o}, 0);
        chk("R2 no redir", {31'd0, redir_valid_o}, 0);
        chk("R2 fault_va held", fault_va_o, 32'hFFFF_FFFF);
        chk("R2 target held", redir_pc_o, 32'h0000_0080);
    endtask

    task automatic t_masked();
        @(negedge clk);
        drive(32'h0000_4444, 1'b0, 2'd0, 32'h2222_2222, 1'b0, '0, 32'h1000_0000, 32'h3000_0000);
        viol_i = 1'b1;
        @(negedge clk);
        viol_i = 1'b0;
        chk("R9 no commit", {31'd0, commit_o}, 0);
        chk("R9 nested", {31'd0, nested_fault_o}, 1);
        chk("R9 fault_va unchanged", fault_va_o, 32'hFFFF_FFFF);
        chk("R9 saved_pc unchanged", saved_pc_o, 32'h0000_2000);
        @(negedge clk);
        chk("R9 nested single", {31'd0, nested_fault_o}, 0);
        chk("R9 no redir", {31'd0, redir_valid_o}, 0);
        chk("R9 target unchanged", redir_pc_o, 32'h0000_0080);
    endtask

    task automatic t_busy_overlap();
        @(negedge clk);
        drive(32'hABCD_0400, 1'b0, 2'd1, 32'h0000_3000, 1'b0, '0, '0, 32'h0001_0000);
        viol_i = 1'b1;
        @(negedge clk);
        drive(32'h5555_5555, 1'b1, 2'd2, 32'h0000_9000, 1'b0, '0, '0, 32'h0002_0000);
        chk("R10 first commit", {31'd0, commit_o}, 1);
        chk("R10 first fault_va", fault_va_o, 32'hABCD_0400);
        @(negedge clk);
        viol_i = 1'b0;
        chk("R10 redir", {31'd0, redir_valid_o}, 1);
        chk("R10 nested", {31'd0, nested_fault_o}, 1);
        chk("R10 target first", redir_pc_o, 32'h0001_0100);
        chk("R10 fault_va kept", fault_va_o, 32'hABCD_0400);
        chk("R10 event kept", {20'd0, event_o}, 32'h0A0);
        @(negedge clk);
        chk("R10 no new commit", {31'd0, commit_o}, 0);
        chk("R10 nested drop", {31'd0, nested_fault_o}, 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_plain();
        t_store_dslot();
        t_idle_hold();
        t_masked();
        t_busy_overlap();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule